// File: doc/BRIEF.md
# Sixteen-bit ALU with status flags

This block is the arithmetic and logic stage of a small 16-bit RISC core. Each cycle it takes a destination operand, a source operand, an operation code, a size select and the current status word. It returns the result, a strobe that says whether the result should be written back, and the status word with the four condition flags replaced. The carry input of add-with-carry is read from bit 0 of the incoming status word. Every other status bit is copied through unchanged.

The datapath is combinational. A parameter adds a copy of the new status word in a register, so that a core which commits flags on the clock edge can take them from there. In byte mode only the low eight bits take part in the flags, and the upper half of the result is zero. Subtraction and comparison both add the inverted source plus one, so the carry reads as "no borrow".

Top module: `alu16_flags`

## Requirements
- R1: Opcode 0 (add) returns dst+src. Opcode 1 (add with carry) returns dst+src+C, where C is status input bit 0. Carry out is the carry from the top bit of the active size.
- R2: Opcode 2 (subtract) and opcode 3 (compare) compute dst+~src+1. Carry is 1 exactly when dst is unsigned greater than or equal to src, which means no borrow.
- R3: Compare updates the flags and holds the write strobe low. Opcodes 0, 1, 2, 4, 5 and 6 raise the write strobe.
- R4: Opcodes 4, 5 and 6 return dst AND src, dst OR src and dst XOR src. For these, V is cleared and C is the inverse of Z.
- R5: For opcodes 0 to 3, V is set exactly when the signed result of the active size overflows its range.
- R6: Z is set when the result of the active size is zero. N equals the top bit of the result of the active size.
- R7: When the size select is 1 (byte), flags come from result bits 7:0, carry is taken out of bit 7, result bits 15:8 are zero, and operand bits 15:8 have no effect.
- R8: Flags sit in the status word at C bit 0, Z bit 1, N bit 2 and V bit 8. All other status bits equal the status input.
- R9: Opcode 7 is reserved. It produces a zero result, a low write strobe, and a status output equal to the status input.
- R10: With the registered option, the registered status output holds the previous cycle's status output and resets to 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the registered status copy |
| rst_n | input | 1 | Active-low asynchronous reset |
| op | input | 3 | Operation code (0 add, 1 add with carry, 2 subtract, 3 compare, 4 AND, 5 OR, 6 XOR, 7 reserved) |
| byte_mode | input | 1 | 1 selects byte size, 0 selects word size |
| dst | input | 16 | Destination operand (left-hand side) |
| src | input | 16 | Source operand |
| sr_in | input | 16 | Current status word; bit 0 supplies the carry input |
| res | output | 16 | Operation result |
| res_we | output | 1 | Result write strobe |
| sr_out | output | 16 | Updated status word (combinational) |
| sr_q | output | 16 | Registered copy of the status output |

## Verification
Three things can happen in the same cycle. The combinational status of a new operation is checked. The registered copy must still show the flags of the operation before it. A byte operation must hide dirty upper operand bytes and incoming status bits. The bench changes operands and opcode at every falling edge with random upper bytes and random status inputs. At each step it judges the combinational outputs against a reference built on integer arithmetic, and it judges the registered output against the expectation stored one step earlier. Directed cases sit at the overflow, zero and borrow boundaries of both sizes.

// File: rtl/alu16_flags.sv
module alu16_flags #(
  parameter int W = 16,
  parameter bit REG_FLAGS = 1'b1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [2:0]   op,
  input  logic         byte_mode,
  input  logic [W-1:0] dst,
  input  logic [W-1:0] src,
  input  logic [W-1:0] sr_in,
  output logic [W-1:0] res,
  output logic         res_we,
  output logic [W-1:0] sr_out,
  output logic [W-1:0] sr_q
);
  localparam int BB = 8;
  localparam int CB = 0;
  localparam int ZB = 1;
  localparam int NB = 2;
  localparam int VB = 8;

  localparam logic [2:0] OP_ADD  = 3'd0;
  localparam logic [2:0] OP_ADDC = 3'd1;
  localparam logic [2:0] OP_SUB  = 3'd2;
  localparam logic [2:0] OP_CMP  = 3'd3;
  localparam logic [2:0] OP_AND  = 3'd4;
  localparam logic [2:0] OP_OR   = 3'd5;
  localparam logic [2:0] OP_XOR  = 3'd6;

  logic is_sub, is_arith, is_logic, cin;
  logic [W-1:0] b_eff, raw;
  logic [W:0]   sum_w;
  logic [BB:0]  sum_b;
  logic         f_n, f_z, f_c, f_v, a_s, b_s;

  assign is_sub   = (op == OP_SUB) || (op == OP_CMP);
  assign is_arith = (op == OP_ADD) || (op == OP_ADDC) || is_sub;
  assign is_logic = (op == OP_AND) || (op == OP_OR) || (op == OP_XOR);
  assign cin      = (op == OP_ADDC) ? sr_in[CB] : is_sub;
  assign b_eff    = is_sub ? ~src : src;

  assign sum_w = {1'b0, dst} + {1'b0, b_eff} + {{W{1'b0}}, cin};
  assign sum_b = {1'b0, dst[BB-1:0]} + {1'b0, b_eff[BB-1:0]} + {{BB{1'b0}}, cin};

  always_comb begin
    unique case (op)
      OP_AND:  raw = dst & src;
      OP_OR:   raw = dst | src;
      OP_XOR:  raw = dst ^ src;
      default: raw = is_arith ? {sum_w[W-1:BB], sum_b[BB-1:0]} : '0;
    endcase
  end

  assign res    = byte_mode ? {{(W-BB){1'b0}}, raw[BB-1:0]} : raw;
  assign res_we = (is_arith || is_logic) && (op != OP_CMP);

  assign a_s = byte_mode ? dst[BB-1]   : dst[W-1];
  assign b_s = byte_mode ? b_eff[BB-1] : b_eff[W-1];
  assign f_n = byte_mode ? raw[BB-1]   : raw[W-1];
  assign f_z = byte_mode ? (raw[BB-1:0] == '0) : (raw == '0);
  assign f_c = is_logic ? ~f_z : (byte_mode ? sum_b[BB] : sum_w[W]);
  assign f_v = is_arith && (a_s == b_s) && (f_n != a_s);

  always_comb begin
    sr_out = sr_in;
    if (is_arith || is_logic) begin
      sr_out[CB] = f_c;
      sr_out[ZB] = f_z;
      sr_out[NB] = f_n;
      sr_out[VB] = f_v;
    end
  end

  generate
    if (REG_FLAGS) begin : g_reg
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sr_q <= '0;
        else        sr_q <= sr_out;
      end
    end else begin : g_comb
      assign sr_q = sr_out;
    end
  endgenerate
endmodule

module alu16_flags_chk #(
  parameter int W = 16,
  parameter bit REG_FLAGS = 1'b1
) (
  input logic         clk,
  input logic         rst_n,
  input logic [2:0]   op,
  input logic         byte_mode,
  input logic [W-1:0] sr_in,
  input logic [W-1:0] res,
  input logic         res_we,
  input logic [W-1:0] sr_out,
  input logic [W-1:0] sr_q
);
  // R3
  cmp_no_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (op == 3'd3) |-> !res_we);
  // R4
  logic_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (op >= 3'd4 && op <= 3'd6) |-> (!sr_out[8] && (sr_out[0] == !sr_out[1])));
  // R7
  byte_upper_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    byte_mode |-> (res[W-1:8] == '0));
  // R8
  sr_passthru_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sr_out[W-1:9] == sr_in[W-1:9]) && (sr_out[7:3] == sr_in[7:3]));
  // R9
  reserved_op_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (op == 3'd7) |-> (!res_we && sr_out == sr_in && res == '0));
  generate
    if (REG_FLAGS) begin : g_q
      // R10
      sr_reg_lag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (sr_q == $past(sr_out)));
    end
  endgenerate
endmodule

bind alu16_flags alu16_flags_chk #(.W(W), .REG_FLAGS(REG_FLAGS)) u_chk (.*);

// File: tb/alu16_flags_bench.sv
module alu16_flags_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [2:0]  op = '0;
  logic        byte_mode = 1'b0;
  logic [15:0] dst = '0, src = '0, sr_in = '0;
  logic [15:0] res, sr_out, sr_q;
  logic        res_we;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 0;
  logic [15:0] prev_sr = '0;
  bit prev_ok = 0;

  always #2.5 clk = ~clk;

  alu16_flags u_alu16_flags (
    .clk(clk), .rst_n(rst_n), .op(op), .byte_mode(byte_mode),
    .dst(dst), .src(src), .sr_in(sr_in),
    .res(res), .res_we(res_we), .sr_out(sr_out), .sr_q(sr_q)
  );

  task automatic chk(input string tag, input logic [15:0] got, input logic [15:0] exp);
    n_cmp++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h (op=%0d byte=%0b dst=%h src=%h sr=%h)",
               tag, got, exp, op, byte_mode, dst, src, sr_in);
    end
  endtask

  function automatic void model(input logic [2:0] o, input bit b, input logic [15:0] d,
                                input logic [15:0] s, input logic [15:0] si,
                                output logic [15:0] r, output bit we, output logic [15:0] so);
    int sz, mask, ud, us, ur, sd, ss, sres, c;
    bit n, z, cy, v;
    sz = b ? 8 : 16;
    mask = (1 << sz) - 1;
    ud = int'(d) & mask;
    us = int'(s) & mask;
    sd = (ud >= (1 << (sz-1))) ? ud - (1 << sz) : ud;
    ss = (us >= (1 << (sz-1))) ? us - (1 << sz) : us;
    c = int'(si[0]);
    v = 0; cy = 0; ur = 0;
    so = si; we = 0;
    case (o)
      3'd0, 3'd1: begin
        if (o == 3'd0) c = 0;
        ur = (ud + us + c) & mask;
        cy = (ud + us + c) > mask;
        sres = sd + ss + c;
        v = (sres > mask/2) || (sres < -(mask/2) - 1);
      end
      3'd2, 3'd3: begin
        ur = (ud - us) & mask;
        cy = ud >= us;
        sres = sd - ss;
        v = (sres > mask/2) || (sres < -(mask/2) - 1);
      end
      3'd4: ur = ud & us;
      3'd5: ur = ud | us;
      3'd6: ur = ud ^ us;
      default: ur = 0;
    endcase
    r = 16'(ur);
    if (o != 3'd7) begin
      n = ur[sz-1];
      z = (ur == 0);
      if (o >= 3'd4) begin cy = !z; v = 0; end
      so[0] = cy; so[1] = z; so[2] = n; so[8] = v;
      we = (o != 3'd3);
    end
  endfunction

  function automatic string tag_of(input logic [2:0] o, input bit b);
    if (b) return "R7";
    case (o)
      3'd0, 3'd1: return "R1";
      3'd2:       return "R2";
      3'd3:       return "R3";
      3'd7:       return "R9";
      default:    return "R4";
    endcase
  endfunction

  task automatic apply(input logic [2:0] o, input bit b, input logic [15:0] d,
                       input logic [15:0] s, input logic [15:0] si);
    logic [15:0] er, es;
    bit ew;
    @(negedge clk);
    if (prev_ok) chk("R10 registered status", sr_q, prev_sr);
    op = o; byte_mode = b; dst = d; src = s; sr_in = si;
    #1;
    model(o, b, d, s, si, er, ew, es);
    chk({tag_of(o, b), " result"}, res, er);
    chk({tag_of(o, b), " write strobe"}, {15'd0, res_we}, {15'd0, ew});
    chk({tag_of(o, b), " R8 status"}, sr_out, es);
    prev_sr = es; prev_ok = 1;
  endtask

  initial begin
    void'($urandom(32'h5EED_0430));
    #1;
    chk("R10 reset value", sr_q, 16'h0000);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 carry in used / ignored
    apply(3'd1, 0, 16'h1000, 16'h0001, 16'h0001);
    chk("R1 addc uses carry", res, 16'h1002);
    apply(3'd0, 0, 16'h1000, 16'h0001, 16'h0001);
    chk("R1 add ignores carry", res, 16'h1001);
    // R5 signed overflow word and byte
    apply(3'd0, 0, 16'h7FFF, 16'h0001, 16'h0000);
    chk("R5 word add overflow", sr_out & 16'h0107, 16'h0104);
    apply(3'd2, 0, 16'h8000, 16'h0001, 16'h0000);
    chk("R5 word sub overflow", sr_out & 16'h0107, 16'h0101);
    apply(3'd0, 1, 16'hAB7F, 16'h0001, 16'h0000);
    chk("R5 byte add overflow", sr_out & 16'h0107, 16'h0104);
    // R6 zero with carry
    apply(3'd0, 0, 16'hFFFF, 16'h0001, 16'h0000);
    chk("R6 zero and carry", sr_out & 16'h0107, 16'h0003);
    // R7 upper bytes ignored
    apply(3'd0, 1, 16'h12FF, 16'h3401, 16'h0000);
    chk("R7 byte wrap result", res, 16'h0000);
    chk("R7 byte wrap flags", sr_out & 16'h0107, 16'h0003);
    // R2 equal and borrow
    apply(3'd2, 0, 16'h1234, 16'h1234, 16'h0000);
    chk("R2 equal no borrow", sr_out & 16'h0107, 16'h0003);
    apply(3'd2, 0, 16'h0000, 16'h0001, 16'h0000);
    chk("R2 borrow", sr_out & 16'h0107, 16'h0004);
    // R3 compare
    apply(3'd3, 0, 16'h0005, 16'h0009, 16'hFEF8);
    chk("R3 compare no write", {15'd0, res_we}, 16'h0000);
    // R4 logic
    apply(3'd4, 0, 16'hF0F0, 16'h0F0F, 16'h0100);
    chk("R4 and zero flags", sr_out & 16'h0107, 16'h0002);
    apply(3'd6, 0, 16'h8000, 16'h0001, 16'h0100);
    chk("R4 xor flags", sr_out & 16'h0107, 16'h0005);
    // R8 other bits and R9 reserved
    apply(3'd5, 0, 16'h0001, 16'h0000, 16'hFEF8);
    chk("R8 pass-through bits", sr_out & 16'hFEF8, 16'hFEF8);
    apply(3'd7, 0, 16'hFFFF, 16'hFFFF, 16'hA5A5);
    chk("R9 reserved status", sr_out, 16'hA5A5);
    for (int i = 0; i < 3000; i++) begin
      logic [15:0] d, s, si;
      logic [2:0] o;
      bit b;
      d = 16'($urandom); s = 16'($urandom); si = 16'($urandom);
      o = 3'($urandom_range(0, 7)); b = 1'($urandom);
      if (i % 7 == 0) d = {d[15:8], 8'h80};
      if (i % 11 == 0) s = d;
      apply(o, b, d, s, si);
    end
    @(negedge clk);
    chk("R10 registered status", sr_q, prev_sr);
    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    #500000;
    if (!done) begin
      done = 1;
      n_cmp++; n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule